// File: doc/BRIEF.md
# Synchronized Conversion Master Controller

This block runs the master side of a handshake that makes two converters start a conversion together. When the arbiter hands it a synchronized request, the block captures a bundle of conversion settings and drives them to the partner converter, along with a request line. The settings are a channel number, a resolution code, an external multiplexer setting, an input group select and a cancel enable. The block then stalls until the partner acknowledges. It issues a one-cycle start pulse to its own converter and shows a busy flag while that conversion runs.

Completion is tracked in two status flags. The local flag is set when the master's own conversion ends. The partner flag is set by a pulse from the partner when the partner's conversion ends. Only when both flags are set does the block raise its service request status bit, and both flags clear in that same step. The service request then holds until software clears it. The requesting logic may withdraw a pending request before the acknowledge arrives. The block then drops back to idle without starting anything.

Top module: `sync_conv_master`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the outputs req_o, start_o, busy_o, loc_done_o, par_done_o and srv_o are all 0.
- R2: A select pulse (sel_i=1) accepted in idle raises req_o in the next cycle. The parameter outputs then equal the parameter inputs present with the select.
- R3: While req_o is high, the parameter outputs and req_o do not change unless withdraw_i or ack_i is applied. A select that arrives while not idle is ignored: it changes neither req_o nor the parameter outputs.
- R4: An acknowledge (ack_i=1) while requesting, without withdraw, gives start_o=1 and busy_o=1 and req_o=0 in the next cycle. start_o lasts exactly one cycle.
- R5: withdraw_i=1 while requesting returns the block to idle in the next cycle, with req_o=0, busy_o=0 and no start pulse. Withdraw wins over an acknowledge in the same cycle.
- R6: conv_done_i=1 while busy clears busy_o and sets loc_done_o in the next cycle. conv_done_i has no effect while the block is not busy.
- R7: A pulse on par_done_i sets par_done_o in the next cycle.
- R8: When loc_done_o and par_done_o are both 1, the next cycle has srv_o=1 and both flags at 0. Either flag alone never sets srv_o.
- R9: sw_clr_i=1 makes srv_o 0 in the next cycle. This takes priority over a set in the same cycle, and the two flags are still consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Arbiter picked a synchronized request |
| chan_i | input | CH_W | Channel number to send |
| res_i | input | RES_W | Resolution code to send |
| emux_i | input | EMUX_W | External multiplexer setting to send |
| grp_i | input | GRP_W | Input group select to send |
| cen_i | input | 1 | Cancel enable to send |
| withdraw_i | input | 1 | Withdraw the pending request |
| ack_i | input | 1 | Partner acknowledge |
| conv_done_i | input | 1 | Local conversion finished pulse |
| par_done_i | input | 1 | Partner conversion finished pulse |
| sw_clr_i | input | 1 | Software clear of the service request |
| req_o | output | 1 | Synchronized request to partner |
| chan_o | output | CH_W | Channel number to partner |
| res_o | output | RES_W | Resolution code to partner |
| emux_o | output | EMUX_W | External multiplexer setting to partner |
| grp_o | output | GRP_W | Group select to partner |
| cen_o | output | 1 | Cancel enable to partner |
| start_o | output | 1 | One-cycle local conversion start |
| busy_o | output | 1 | Master of a running synchronized conversion |
| loc_done_o | output | 1 | Local completion flag |
| par_done_o | output | 1 | Partner completion flag |
| srv_o | output | 1 | Service request status bit |

## Verification
The bench checks the partner pulse arriving both before and after the local completion. A design that counts one flag alone as enough would raise srv_o early, and a design that fails to consume the flags would leave them set after the request. The bench applies withdraw and acknowledge in the same cycle and applies a late select while waiting or converting. A design with the wrong priority would start a conversion, or would corrupt the bundle the partner is sampling. The bench also applies a software clear in the very cycle a service request would be set, which catches a design where the set overrides the clear.

// File: rtl/sync_conv_master_pkg.sv
package sync_conv_master_pkg;

    typedef enum logic [1:0] {
        SMC_IDLE = 2'd0,
        SMC_WAIT = 2'd1,
        SMC_CONV = 2'd2
    } smc_state_e;

    localparam int SMC_CH_W_DEF   = 5;
    localparam int SMC_RES_W_DEF  = 2;
    localparam int SMC_EMUX_W_DEF = 3;
    localparam int SMC_GRP_W_DEF  = 2;

    function automatic logic smc_is_conv(smc_state_e s);
        return s == SMC_CONV;
    endfunction

    function automatic logic smc_is_wait(smc_state_e s);
        return s == SMC_WAIT;
    endfunction

endpackage

// File: rtl/smc_req_fsm.sv
module smc_req_fsm
    import sync_conv_master_pkg::*;
#(
    parameter int PRM_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic [PRM_W-1:0] prm_i,
    input  logic             withdraw_i,
    input  logic             ack_i,
    input  logic             conv_done_i,
    output logic             req_o,
    output logic [PRM_W-1:0] prm_o,
    output logic             start_o,
    output logic             busy_o,
    output logic             done_evt_o
);

    smc_state_e       state_q, state_d;
    logic [PRM_W-1:0] prm_q;
    logic             start_q;
    logic             accept;
    logic             go;

    assign accept = (state_q == SMC_IDLE) && sel_i;
    assign go     = smc_is_wait(state_q) && !withdraw_i && ack_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMC_IDLE: if (sel_i) state_d = SMC_WAIT;
            SMC_WAIT: begin
                if (withdraw_i)  state_d = SMC_IDLE;
                else if (ack_i)  state_d = SMC_CONV;
            end
            SMC_CONV: if (conv_done_i) state_d = SMC_IDLE;
            default:  state_d = SMC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SMC_IDLE;
            prm_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= go;
            if (accept) prm_q <= prm_i;
        end
    end

    assign req_o      = smc_is_wait(state_q);
    assign prm_o      = prm_q;
    assign start_o    = start_q;
    assign busy_o     = smc_is_conv(state_q);
    assign done_evt_o = smc_is_conv(state_q) && conv_done_i;

    // R2: a select in idle raises the request in the next cycle
    p_sel_req_r2: assert property (@(posedge clk) disable iff (rst)
        (!req_o && !busy_o && sel_i) |=> (req_o && prm_o == $past(prm_i)));

    // R3: the bundle stays stable while the request is held
    p_prm_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (req_o && !withdraw_i && !ack_i) |=> (req_o && $stable(prm_o)));

    // R4: start is a single-cycle pulse that follows an acknowledge
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);
    p_ack_start_r4: assert property (@(posedge clk) disable iff (rst)
        (req_o && ack_i && !withdraw_i) |=> (start_o && busy_o && !req_o));

    // R5: withdraw returns to idle without a start
    p_withdraw_r5: assert property (@(posedge clk) disable iff (rst)
        (req_o && withdraw_i) |=> (!req_o && !busy_o && !start_o));

endmodule

// File: rtl/smc_flags.sv
module smc_flags (
    input  logic clk,
    input  logic rst,
    input  logic done_evt_i,
    input  logic par_done_i,
    input  logic sw_clr_i,
    output logic loc_o,
    output logic par_o,
    output logic srv_o
);

    logic loc_q, par_q, srv_q;
    logic fire;

    assign fire = loc_q && par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q <= 1'b0;
            par_q <= 1'b0;
            srv_q <= 1'b0;
        end else begin
            loc_q <= done_evt_i || (loc_q && !fire);
            par_q <= par_done_i || (par_q && !fire);
            srv_q <= !sw_clr_i && (srv_q || fire);
        end
    end

    assign loc_o = loc_q;
    assign par_o = par_q;
    assign srv_o = srv_q;

    // R6: end of the local conversion sets the local flag
    p_loc_set_r6: assert property (@(posedge clk) disable iff (rst)
        done_evt_i |=> loc_o);

    // R7: partner pulse sets the partner flag
    p_par_set_r7: assert property (@(posedge clk) disable iff (rst)
        par_done_i |=> par_o);

    // R8: both flags give a service request and are consumed
    p_fire_r8: assert property (@(posedge clk) disable iff (rst)
        (loc_o && par_o && !sw_clr_i && !done_evt_i && !par_done_i)
        |=> (srv_o && !loc_o && !par_o));
    p_alone_r8: assert property (@(posedge clk) disable iff (rst)
        (!srv_o && !(loc_o && par_o)) |=> !srv_o);

    // R9: software clear wins
    p_swclr_r9: assert property (@(posedge clk) disable iff (rst)
        sw_clr_i |=> !srv_o);

endmodule

// File: rtl/sync_conv_master.sv
module sync_conv_master
    import sync_conv_master_pkg::*;
#(
    parameter int CH_W   = SMC_CH_W_DEF,
    parameter int RES_W  = SMC_RES_W_DEF,
    parameter int EMUX_W = SMC_EMUX_W_DEF,
    parameter int GRP_W  = SMC_GRP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [RES_W-1:0]  res_i,
    input  logic [EMUX_W-1:0] emux_i,
    input  logic [GRP_W-1:0]  grp_i,
    input  logic              cen_i,
    input  logic              withdraw_i,
    input  logic              ack_i,
    input  logic              conv_done_i,
    input  logic              par_done_i,
    input  logic              sw_clr_i,
    output logic              req_o,
    output logic [CH_W-1:0]   chan_o,
    output logic [RES_W-1:0]  res_o,
    output logic [EMUX_W-1:0] emux_o,
    output logic [GRP_W-1:0]  grp_o,
    output logic              cen_o,
    output logic              start_o,
    output logic              busy_o,
    output logic              loc_done_o,
    output logic              par_done_o,
    output logic              srv_o
);

    localparam int RES_LO  = CH_W;
    localparam int EMUX_LO = RES_LO + RES_W;
    localparam int GRP_LO  = EMUX_LO + EMUX_W;
    localparam int CEN_LO  = GRP_LO + GRP_W;
    localparam int PRM_W   = CEN_LO + 1;

    logic [PRM_W-1:0] prm_in, prm_out;
    logic             done_evt;

    assign prm_in = {cen_i, grp_i, emux_i, res_i, chan_i};

    smc_req_fsm #(.PRM_W(PRM_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sel_i       (sel_i),
        .prm_i       (prm_in),
        .withdraw_i  (withdraw_i),
        .ack_i       (ack_i),
        .conv_done_i (conv_done_i),
        .req_o       (req_o),
        .prm_o       (prm_out),
        .start_o     (start_o),
        .busy_o      (busy_o),
        .done_evt_o  (done_evt)
    );

    smc_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .done_evt_i (done_evt),
        .par_done_i (par_done_i),
        .sw_clr_i   (sw_clr_i),
        .loc_o      (loc_done_o),
        .par_o      (par_done_o),
        .srv_o      (srv_o)
    );

    assign chan_o = prm_out[RES_LO-1:0];
    assign res_o  = prm_out[EMUX_LO-1:RES_LO];
    assign emux_o = prm_out[GRP_LO-1:EMUX_LO];
    assign grp_o  = prm_out[CEN_LO-1:GRP_LO];
    assign cen_o  = prm_out[CEN_LO];

    // R6: a done pulse outside a running conversion leaves the flag alone
    p_idle_done_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !loc_done_o && conv_done_i && !start_o) |=> !loc_done_o);

endmodule

// File: tb/sync_conv_master_tb_top.sv
module sync_conv_master_tb_top;

    localparam int CH_W = 5, RES_W = 2, EMUX_W = 3, GRP_W = 2;
    localparam int NV = 8;
    // vector fields: [4:0] chan, [6:5] res, [9:7] emux, [11:10] grp,
    // [12] cen, [13] partner first, [14] withdraw
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 2'd1, 3'd5, 2'd2, 5'd17},
        {1'b0, 1'b1, 1'b0, 2'd3, 3'd0, 2'd1, 5'd3},
        {1'b1, 1'b0, 1'b1, 2'd2, 3'd7, 2'd3, 5'd31},
        {1'b1, 1'b1, 1'b0, 2'd0, 3'd2, 2'd0, 5'd9},
        {1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 5'd0},
        {1'b0, 1'b1, 1'b1, 2'd3, 3'd7, 2'd3, 5'd30},
        {1'b1, 1'b0, 1'b0, 2'd1, 3'd4, 2'd2, 5'd12},
        {1'b0, 1'b0, 1'b1, 2'd2, 3'd3, 2'd1, 5'd21}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_i = 0, cen_i = 0, withdraw_i = 0, ack_i = 0;
    logic conv_done_i = 0, par_done_i = 0, sw_clr_i = 0;
    logic [CH_W-1:0]   chan_i = '0;
    logic [RES_W-1:0]  res_i = '0;
    logic [EMUX_W-1:0] emux_i = '0;
    logic [GRP_W-1:0]  grp_i = '0;
    logic req_o, cen_o, start_o, busy_o, loc_done_o, par_done_o, srv_o;
    logic [CH_W-1:0]   chan_o;
    logic [RES_W-1:0]  res_o;
    logic [EMUX_W-1:0] emux_o;
    logic [GRP_W-1:0]  grp_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sync_conv_master #(.CH_W(CH_W), .RES_W(RES_W), .EMUX_W(EMUX_W), .GRP_W(GRP_W)) dut_i (
        .clk(clk), .rst(rst), .sel_i(sel_i), .chan_i(chan_i), .res_i(res_i),
        .emux_i(emux_i), .grp_i(grp_i), .cen_i(cen_i), .withdraw_i(withdraw_i),
        .ack_i(ack_i), .conv_done_i(conv_done_i), .par_done_i(par_done_i),
        .sw_clr_i(sw_clr_i), .req_o(req_o), .chan_o(chan_o), .res_o(res_o),
        .emux_o(emux_o), .grp_o(grp_o), .cen_o(cen_o), .start_o(start_o),
        .busy_o(busy_o), .loc_done_o(loc_done_o), .par_done_o(par_done_o),
        .srv_o(srv_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] prm_now();
        return {cen_o, grp_o, emux_o, res_o, chan_o};
    endfunction

    task automatic drive_prm(input logic [12:0] p);
        {cen_i, grp_i, emux_i, res_i, chan_i} = p;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 req reset", req_o, 0);
        chk("R1 srv reset", {start_o, busy_o, loc_done_o, par_done_o, srv_o}, 0);
        rst = 0;
        step();
        chk("R1 after release", {req_o, start_o, busy_o, loc_done_o, par_done_o, srv_o}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [12:0] p;
            logic pf, wd;
            p  = VEC[v][12:0];
            pf = VEC[v][13];
            wd = VEC[v][14];
            sel_i = 1; drive_prm(p);
            step();
            sel_i = 0;
            chk("R2 req", req_o, 1);
            chk("R2 prm", prm_now(), p);
            sel_i = 1; drive_prm(~p);
            step();
            sel_i = 0;
            chk("R3 held req", req_o, 1);
            chk("R3 held prm", prm_now(), p);
            if (wd) begin
                withdraw_i = 1; ack_i = pf;
                step();
                withdraw_i = 0; ack_i = 0;
                chk("R5 withdraw", {req_o, start_o, busy_o}, 0);
                step();
                chk("R5 no late start", {start_o, busy_o}, 0);
            end else begin
                ack_i = 1;
                step();
                ack_i = 0;
                chk("R4 start", {start_o, busy_o, req_o}, 3'b110);
                step();
                chk("R4 pulse end", {start_o, busy_o}, 2'b01);
                if (pf) begin
                    par_done_i = 1;
                    step();
                    par_done_i = 0;
                    chk("R7 partner first", par_done_o, 1);
                    chk("R8 partner alone", srv_o, 0);
                end
                conv_done_i = 1;
                step();
                conv_done_i = 0;
                chk("R6 done", {busy_o, loc_done_o}, 2'b01);
                chk("R8 no early srv", srv_o, 0);
                if (!pf) begin
                    par_done_i = 1;
                    step();
                    par_done_i = 0;
                    chk("R7 partner", par_done_o, 1);
                end
                step();
                chk("R8 fire", {srv_o, loc_done_o, par_done_o}, 3'b100);
                sw_clr_i = 1;
                step();
                sw_clr_i = 0;
                chk("R9 clear", srv_o, 0);
            end
        end

        // R3: select while converting is ignored; R6: stray done ignored
        conv_done_i = 1;
        step();
        conv_done_i = 0;
        chk("R6 idle done ignored", loc_done_o, 0);
        sel_i = 1; drive_prm(13'h0A5A);
        step();
        sel_i = 0; ack_i = 1;
        step();
        ack_i = 0;
        sel_i = 1; drive_prm(13'h1111);
        step();
        sel_i = 0;
        chk("R3 busy sel req", req_o, 0);
        chk("R3 busy sel prm", prm_now(), 13'h0A5A);

        // R9: software clear in the cycle the request would be set
        conv_done_i = 1; par_done_i = 1;
        step();
        conv_done_i = 0; par_done_i = 0;
        chk("R8 both set", {loc_done_o, par_done_o}, 2'b11);
        sw_clr_i = 1;
        step();
        sw_clr_i = 0;
        chk("R9 priority", {srv_o, loc_done_o, par_done_o}, 3'b000);
        chk("R6 idle after", busy_o, 0);

        // R1: reset while requesting
        sel_i = 1; drive_prm(13'h0123);
        step();
        sel_i = 0;
        rst = 1;
        step();
        chk("R1 mid reset", {req_o, busy_o, prm_now()}, 0);
        rst = 0;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule